// File: doc/BRIEF.md
# Output Short-Circuit Fault Autoretry Controller

This block supervises a single digital output driver whose current limiter raises a digital overcurrent flag. When the flag persists long enough while the driver is being asked to drive, the block declares a short. It sets a live fault bit and a sticky interrupt bit, and it pulls an active-low interrupt request. A fixed time after the overcurrent began, it switches the driver off.

The driver is not left off for good. The block runs a retry schedule. Short probe windows re-enable the driver, one window in every retry period. If overcurrent is seen anywhere in a window, the driver goes back off for the next period. If a window ends clean, the live fault bit drops and the driver again follows its request. The sticky interrupt bit is separate from the live bit. It is cleared only by a status-read strobe.

All durations are counted in ticks from an external microsecond prescaler. They are parameters, so the same logic serves the nominal timings (a qualification time of a few tens to a few hundred microseconds, a 440 µs shutdown and probe, a 26 ms period) and short test timings.

Top module: `short_retry_top`

## Requirements
- R1: After reset, faultLive = 0, faultSticky = 0 and irqN = 1 (irqN is active low).
- R2: With no fault pending, drvEn equals driveReq in every cycle. drvEn is never high while driveReq is low.
- R3: A fault is declared at the clock edge that samples the QUAL_TICKS-th tick during which ocFlag and driveReq were both high without a break. If ocFlag drops before that, the count restarts and no fault is declared.
- R4: Only cycles with tickUs = 1 advance any duration. Overcurrent while driveReq is low is ignored.
- R5: At the edge that declares a fault, faultLive and faultSticky both become 1 and irqN becomes 0.
- R6: The driver turns off at the edge that samples the OFF_TICKS-th qualifying tick counted from the start of the overcurrent, independent of ocFlag after qualification.
- R7: While faulted, probe windows of PROBE_TICKS ticks start every PERIOD_TICKS ticks. The first starts PERIOD_TICKS − PROBE_TICKS ticks after shutdown. Between windows drvEn = 0.
- R8: A window in which ocFlag is seen high in any cycle returns the driver to off. faultLive stays 1.
- R9: A window that completes with ocFlag low throughout clears faultLive and returns drvEn to following driveReq. faultSticky is unchanged.
- R10: A one-cycle statusRd clears faultSticky and raises irqN at the next edge, even while faultLive is still 1.
- R11: If statusRd coincides with the edge that declares a fault, faultSticky stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickUs | input | 1 | One-cycle pulse from the microsecond prescaler |
| driveReq | input | 1 | Request to enable the output driver |
| ocFlag | input | 1 | Overcurrent flag from the driver's current limiter |
| statusRd | input | 1 | Status-read strobe; clears the sticky interrupt bit |
| drvEn | output | 1 | Enable to the output driver |
| faultLive | output | 1 | Short currently believed present |
| faultSticky | output | 1 | Latched fault interrupt bit |
| irqN | output | 1 | Active-low interrupt request |

## Verification
A wrong state in the sequencer shows up at drvEn within one tick. A probe opens early or late, or the driver stays on past the shutdown instant, and an edge-by-edge timeline catches it at the exact edge. A miscounting duration counter moves the qualification or the shutdown edge by at least one tick, which the sweeps over burst length and held overcurrent detect. A broken sticky path is visible on the first statusRd or fault event that follows.

// File: rtl/short_retry_pkg.sv
package short_retry_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_REST  = 2'd2,
    ST_PROBE = 2'd3
  } retryState_t;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic sawClr;
    logic liveSet;
    logic liveClr;
    logic stickySet;
  } ctlStrobe_t;

endpackage

// File: rtl/short_retry_datapath.sv
module short_retry_datapath
  import short_retry_pkg::*;
#(
  parameter int QUAL_TICKS   = 100,
  parameter int OFF_TICKS    = 440,
  parameter int PROBE_TICKS  = 440,
  parameter int PERIOD_TICKS = 26000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t stb,
  input  logic       ocFlag,
  input  logic       statusRd,
  output logic       hitQual,
  output logic       hitOff,
  output logic       hitGap,
  output logic       hitProbe,
  output logic       seenOc,
  output logic       faultLive,
  output logic       faultSticky
);

  localparam int GAP_TICKS = PERIOD_TICKS - PROBE_TICKS;
  localparam int MAX_A     = (OFF_TICKS > GAP_TICKS) ? OFF_TICKS : GAP_TICKS;
  localparam int CNT_MAX   = (MAX_A > PROBE_TICKS) ? MAX_A : PROBE_TICKS;
  localparam int CW        = $clog2(CNT_MAX + 1);

  localparam logic [CW-1:0] QUAL_C  = CW'(QUAL_TICKS);
  localparam logic [CW-1:0] OFF_C   = CW'(OFF_TICKS);
  localparam logic [CW-1:0] GAP_C   = CW'(GAP_TICKS);
  localparam logic [CW-1:0] PROBE_C = CW'(PROBE_TICKS);

  logic [CW-1:0] tickCnt;
  logic [CW-1:0] cntNext;
  logic          sawOc;

  assign cntNext  = tickCnt + 1'b1;
  assign hitQual  = (cntNext == QUAL_C);
  assign hitOff   = (cntNext == OFF_C);
  assign hitGap   = (cntNext == GAP_C);
  assign hitProbe = (cntNext == PROBE_C);
  assign seenOc   = sawOc | ocFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (stb.cntClr) begin
      tickCnt <= '0;
    end else if (stb.cntInc) begin
      tickCnt <= cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sawOc <= 1'b0;
    end else if (stb.sawClr) begin
      sawOc <= 1'b0;
    end else begin
      sawOc <= seenOc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultLive <= 1'b0;
    end else if (stb.liveSet) begin
      faultLive <= 1'b1;
    end else if (stb.liveClr) begin
      faultLive <= 1'b0;
    end
  end

  // A new event outranks a read in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultSticky <= 1'b0;
    end else if (stb.stickySet) begin
      faultSticky <= 1'b1;
    end else if (statusRd) begin
      faultSticky <= 1'b0;
    end
  end

endmodule

// File: rtl/short_retry_ctrl.sv
module short_retry_ctrl
  import short_retry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickUs,
  input  logic       driveReq,
  input  logic       ocFlag,
  input  logic       hitQual,
  input  logic       hitOff,
  input  logic       hitGap,
  input  logic       hitProbe,
  input  logic       seenOc,
  output ctlStrobe_t stb,
  output logic       drvEn
);

  retryState_t state;
  retryState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    drvEn     = 1'b0;
    unique case (state)
      ST_RUN: begin
        drvEn = driveReq;
        if (driveReq && ocFlag) begin
          if (tickUs) begin
            stb.cntInc = 1'b1;
            if (hitQual) begin
              stb.liveSet   = 1'b1;
              stb.stickySet = 1'b1;
              stateNext     = ST_HOLD;
            end
          end
        end else begin
          stb.cntClr = 1'b1;
        end
      end
      ST_HOLD: begin
        drvEn = driveReq;
        if (tickUs) begin
          stb.cntInc = 1'b1;
          if (hitOff) begin
            stb.cntClr = 1'b1;
            stateNext  = ST_REST;
          end
        end
      end
      ST_REST: begin
        if (tickUs) begin
          stb.cntInc = 1'b1;
          if (hitGap) begin
            stb.cntClr = 1'b1;
            stb.sawClr = 1'b1;
            stateNext  = ST_PROBE;
          end
        end
      end
      ST_PROBE: begin
        drvEn = driveReq;
        if (tickUs) begin
          stb.cntInc = 1'b1;
          if (hitProbe) begin
            stb.cntClr = 1'b1;
            if (seenOc) begin
              stateNext = ST_REST;
            end else begin
              stb.liveClr = 1'b1;
              stateNext   = ST_RUN;
            end
          end
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

endmodule

// File: rtl/short_retry_top.sv
module short_retry_top
  import short_retry_pkg::*;
#(
  parameter int QUAL_TICKS   = 100,
  parameter int OFF_TICKS    = 440,
  parameter int PROBE_TICKS  = 440,
  parameter int PERIOD_TICKS = 26000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickUs,
  input  logic driveReq,
  input  logic ocFlag,
  input  logic statusRd,
  output logic drvEn,
  output logic faultLive,
  output logic faultSticky,
  output logic irqN
);

  ctlStrobe_t stb;
  logic hitQual, hitOff, hitGap, hitProbe, seenOc;

  short_retry_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickUs   (tickUs),
    .driveReq (driveReq),
    .ocFlag   (ocFlag),
    .hitQual  (hitQual),
    .hitOff   (hitOff),
    .hitGap   (hitGap),
    .hitProbe (hitProbe),
    .seenOc   (seenOc),
    .stb      (stb),
    .drvEn    (drvEn)
  );

  short_retry_datapath #(
    .QUAL_TICKS   (QUAL_TICKS),
    .OFF_TICKS    (OFF_TICKS),
    .PROBE_TICKS  (PROBE_TICKS),
    .PERIOD_TICKS (PERIOD_TICKS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .ocFlag      (ocFlag),
    .statusRd    (statusRd),
    .hitQual     (hitQual),
    .hitOff      (hitOff),
    .hitGap      (hitGap),
    .hitProbe    (hitProbe),
    .seenOc      (seenOc),
    .faultLive   (faultLive),
    .faultSticky (faultSticky)
  );

  assign irqN = ~faultSticky;

endmodule

// File: rtl/short_retry_checker.sv
module short_retry_checker (
  input logic clk,
  input logic rstN,
  input logic tickUs,
  input logic driveReq,
  input logic ocFlag,
  input logic statusRd,
  input logic drvEn,
  input logic faultLive,
  input logic faultSticky,
  input logic irqN
);

  // R2
  drv_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    drvEn |-> driveReq);

  // R3
  qual_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLive) |-> ($past(ocFlag) && $past(driveReq) && $past(tickUs)));

  // R5
  live_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLive) |-> (faultSticky && !irqN));

  // R9
  live_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLive) |-> (!$past(ocFlag) && $past(tickUs)));

  // R10
  sticky_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultSticky) |-> ($past(statusRd) && irqN));

endmodule

bind short_retry_top short_retry_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tickUs      (tickUs),
  .driveReq    (driveReq),
  .ocFlag      (ocFlag),
  .statusRd    (statusRd),
  .drvEn       (drvEn),
  .faultLive   (faultLive),
  .faultSticky (faultSticky),
  .irqN        (irqN)
);

// File: tb/tb_short_retry_top.sv
`timescale 1ns/1ps
module tb_short_retry_top;

  localparam int Q   = 3;
  localparam int OFF = 5;
  localparam int PR  = 2;
  localparam int PER = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickUs = 1'b1;
  logic driveReq = 1'b0;
  logic ocFlag = 1'b0;
  logic statusRd = 1'b0;
  logic drvEn, faultLive, faultSticky, irqN;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  short_retry_top #(
    .QUAL_TICKS(Q), .OFF_TICKS(OFF), .PROBE_TICKS(PR), .PERIOD_TICKS(PER)
  ) dut (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .driveReq(driveReq),
    .ocFlag(ocFlag), .statusRd(statusRd), .drvEn(drvEn),
    .faultLive(faultLive), .faultSticky(faultSticky), .irqN(irqN)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickUs = 1'b1; driveReq = 1'b0; ocFlag = 1'b0; statusRd = 1'b0;
    step();
    rstN = 1'b1;
    step();
  endtask

  // Expected driver enable n edges after overcurrent began (held high)
  function automatic logic drvExp(input int n);
    if (n < OFF) return 1'b1;
    return ((n - OFF) % PER) >= (PER - PR);
  endfunction

  initial begin
    #100000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 live", faultLive, 1'b0);
    check("R1 sticky", faultSticky, 1'b0);
    check("R1 irqN", irqN, 1'b1);

    // R2 pass-through
    for (int v = 0; v < 4; v++) begin
      driveReq = v[0];
      step();
      check("R2 drvEn follows", drvEn, v[0]);
    end

    // R3 bursts shorter than qualification, and interrupted bursts
    for (int len = 1; len < Q; len++) begin
      doReset();
      driveReq = 1'b1;
      ocFlag = 1'b1;
      for (int k = 0; k < len; k++) step();
      ocFlag = 1'b0;
      step();
      ocFlag = 1'b1;
      for (int k = 0; k < len; k++) step();
      ocFlag = 1'b0;
      step();
      check("R3 short burst no fault", faultLive, 1'b0);
      check("R3 short burst no sticky", faultSticky, 1'b0);
      check("R3 driver still on", drvEn, 1'b1);
    end

    // R4 ticks gate counting; overcurrent ignored while not driving
    doReset();
    driveReq = 1'b0; ocFlag = 1'b1;
    for (int k = 0; k < 20; k++) step();
    check("R4 no fault without driveReq", faultLive, 1'b0);
    check("R4 drvEn low", drvEn, 1'b0);
    driveReq = 1'b1; tickUs = 1'b0;
    for (int k = 0; k < 20; k++) step();
    check("R4 no fault without ticks", faultLive, 1'b0);
    for (int n = 1; n <= 2 * Q; n++) begin
      tickUs = (n % 2 == 0);
      step();
      check("R4 fault after Q ticks", faultLive, (n >= 2 * Q) ? 1'b1 : 1'b0);
    end
    tickUs = 1'b1;

    // R5 R6 R7 R8 full timeline with overcurrent held
    doReset();
    driveReq = 1'b1; ocFlag = 1'b1;
    for (int n = 1; n <= OFF + 2 * PER; n++) begin
      step();
      check("R5 live", faultLive, (n >= Q) ? 1'b1 : 1'b0);
      check("R5 irqN", irqN, (n >= Q) ? 1'b0 : 1'b1);
      if (n <= OFF) check("R6 shutdown edge", drvEn, drvExp(n));
      else          check("R7 R8 retry schedule", drvEn, drvExp(n));
    end

    // R9 short removed: next clean window restores driving
    ocFlag = 1'b0;
    for (int n = OFF + 2 * PER + 1; n <= OFF + 3 * PER + 2; n++) begin
      step();
      if (n < OFF + 3 * PER) begin
        check("R9 window still scheduled", drvEn, drvExp(n));
        check("R9 live held", faultLive, 1'b1);
      end else begin
        check("R9 driving resumed", drvEn, 1'b1);
        check("R9 live cleared", faultLive, 1'b0);
        check("R9 sticky kept", faultSticky, 1'b1);
      end
    end

    // R10 status read clears sticky
    statusRd = 1'b1;
    step();
    statusRd = 1'b0;
    check("R10 sticky cleared", faultSticky, 1'b0);
    check("R10 irqN released", irqN, 1'b1);

    // R11 read coinciding with the declaring edge; then R10 with live fault
    doReset();
    driveReq = 1'b1; ocFlag = 1'b1;
    for (int n = 1; n <= Q; n++) begin
      statusRd = (n == Q);
      step();
    end
    statusRd = 1'b0;
    check("R11 sticky survives read", faultSticky, 1'b1);
    check("R11 live set", faultLive, 1'b1);
    step();
    statusRd = 1'b1;
    step();
    statusRd = 1'b0;
    check("R10 sticky cleared while live", faultSticky, 1'b0);
    check("R10 live untouched", faultLive, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule